// File: doc/BRIEF.md
# Transceiver TX Reset Sequencer

This block brings the transmit side of a serial transceiver out of reset in a fixed order. A reset request powers down the transmit PLL and holds the transmit digital logic in reset. The PLL power-down is then released after a set time. The block waits for the PLL to report lock, with that lock status first passed through a hysteresis filter. After lock, it holds the digital reset for a further set time before releasing it and flagging the path as ready.

All times are given as nanosecond parameters together with a clock-period parameter. Each is turned into a whole number of cycles by rounding up. A recovery parameter decides what happens when filtered lock is lost while the path is running:
- automatic re-reset;
- leave it alone (manual);
- per-channel choice at runtime through a select input.

Another parameter chooses between one independent sequencer per channel and a single sequencer whose outputs drive every channel. A third parameter decides whether the reset request is passed through a two-stage synchronizer before the sequencer uses it, or is used raw.

Top module: `txrst_ctrl`

## Requirements
- R1: While `rst_req` is high, every `pll_pd` bit and every `tx_dig_rst` bit is 1 and every `tx_ready` bit is 0. This applies from the moment the request rises, without waiting for a clock edge.
- R2: The power-down time in cycles is ceil(PD_NS / CLK_NS). After `rst_req` falls, `pll_pd` falls on exactly the rising edge whose count equals the synchronizer stage count (2 when synchronized, 0 when raw) plus that power-down time.
- R3: `tx_dig_rst` stays 1 after power-down ends until filtered lock is seen and then a hold of ceil(HOLD_NS / CLK_NS) cycles has elapsed. Once lock is held steady, it falls on the (hysteresis cycles + 1 + hold cycles)-th rising edge after the raw lock input rises.
- R4: The filtered lock goes high only after the raw lock input has been sampled high on ceil(HYST_NS / CLK_NS) consecutive edges. Any low sample restarts the count, so a shorter lock pulse does not release `tx_dig_rst`. A hysteresis of 0 passes lock straight through.
- R5: In automatic recovery, a drop of the raw lock input on a running channel sets that channel's `tx_dig_rst` to 1 on the second rising edge after the drop. The sequence then resumes from waiting for lock.
- R6: In manual recovery, a loss of lock on a running channel leaves `tx_dig_rst` at 0 and `tx_ready` at 1.
- R7: With RECOVERY = 2, bit c of `manual_sel` chooses the recovery for channel c: 1 selects manual, 0 selects automatic. RECOVERY = 0 fixes automatic and RECOVERY = 1 fixes manual.
- R8: With PER_CHANNEL = 1, each channel is sequenced from its own lock bit, and a lock loss on one channel does not disturb another. With PER_CHANNEL = 0, one sequencer uses the AND of all lock bits and drives every channel identically.
- R9: SYNC_REQ = 1 releases the request through two clock stages. SYNC_REQ = 0 uses the request directly, with no added release delay.
- R10: `tx_ready` of a channel is 1 exactly when that channel's transmit digital reset has been released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_req | input | 1 | Reset request, active high, may be asynchronous |
| pll_locked | input | NCH | Raw PLL lock status per channel |
| manual_sel | input | NCH | Runtime recovery choice per channel (1 = manual), used when RECOVERY = 2 |
| pll_pd | output | NCH | PLL power-down per channel |
| tx_dig_rst | output | NCH | Transmit digital reset per channel |
| tx_ready | output | NCH | Transmit path ready per channel |

## Verification
The bench builds two instances, both with a 10 ns clock period, 45 ns power-down, 25 ns hold and 35 ns hysteresis. These values round to 5, 3 and 4 cycles, so the rounding-up rule shows directly in the measured edge counts.

The first instance uses per-channel sequencers, runtime-selectable recovery and a synchronized request. This lets one run reach the automatic and manual reactions, channel independence and the two-stage release delay.

The second instance uses one shared sequencer, fixed automatic recovery and a raw request. This brings in the AND of the lock bits, identical driving of all channels and the release path with no synchronizer stages.

// File: rtl/txrst_pkg.sv
package txrst_pkg;

    typedef enum logic [1:0] {
        ST_PWRDN     = 2'd0,
        ST_WAIT_LOCK = 2'd1,
        ST_HOLD      = 2'd2,
        ST_RUN       = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic pll_pd;
        logic tx_rst;
        logic ready;
    } seq_out_t;

    localparam int RECOVER_AUTO   = 0;
    localparam int RECOVER_MANUAL = 1;
    localparam int RECOVER_PORT   = 2;

    localparam int REQ_SYNC_STAGES = 2;

    function automatic int unsigned ns_to_cycles(input longint unsigned ns,
                                                 input longint unsigned period_ns);
        return int'((ns + period_ns - 1) / period_ns);
    endfunction

    function automatic int unsigned cnt_bits(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/txrst_req_cond.sv
module txrst_req_cond
    import txrst_pkg::*;
#(
    parameter bit SYNC_REQ = 1'b1
) (
    input  logic clk,
    input  logic req_raw,
    output logic req_eff
);
    generate
        if (SYNC_REQ) begin : g_sync
            logic [REQ_SYNC_STAGES-1:0] stage_q;
            always_ff @(posedge clk or posedge req_raw) begin
                if (req_raw) stage_q <= '1;
                else         stage_q <= {stage_q[REQ_SYNC_STAGES-2:0], 1'b0};
            end
            assign req_eff = stage_q[REQ_SYNC_STAGES-1];

            a_r9_release_delayed: assert property (@(posedge clk)
                $fell(req_eff) |-> !$past(req_raw));
        end else begin : g_raw
            assign req_eff = req_raw;
        end
    endgenerate
endmodule

// File: rtl/txrst_lock_filter.sv
module txrst_lock_filter
    import txrst_pkg::*;
#(
    parameter int unsigned HYST_CYC = 4
) (
    input  logic clk,
    input  logic clr,
    input  logic lock_raw,
    output logic lock_ok
);
    generate
        if (HYST_CYC == 0) begin : g_pass
            assign lock_ok = lock_raw;
        end else begin : g_hyst
            localparam int unsigned CW = cnt_bits(HYST_CYC);
            localparam logic [CW-1:0] LIMIT = CW'(HYST_CYC);
            logic [CW-1:0] run_q;
            logic          ok_q;

            always_ff @(posedge clk) begin
                if (clr || !lock_raw) begin
                    run_q <= '0;
                    ok_q  <= 1'b0;
                end else begin
                    if (run_q < LIMIT) run_q <= run_q + 1'b1;
                    ok_q <= (run_q >= LIMIT - 1'b1);
                end
            end
            assign lock_ok = ok_q;

            a_r4_low_sample_clears: assert property (@(posedge clk) disable iff (clr)
                !lock_raw |=> !lock_ok);
            a_r4_rise_needs_lock: assert property (@(posedge clk) disable iff (clr)
                $rose(lock_ok) |-> $past(lock_raw));
        end
    endgenerate
endmodule

// File: rtl/txrst_seq.sv
module txrst_seq
    import txrst_pkg::*;
#(
    parameter int unsigned PD_CYC   = 100,
    parameter int unsigned HOLD_CYC = 2
) (
    input  logic     clk,
    input  logic     clr,
    input  logic     lock_ok,
    input  logic     manual,
    output seq_out_t out
);
    localparam int unsigned CNT_MAX = (PD_CYC > HOLD_CYC) ? PD_CYC : HOLD_CYC;
    localparam int unsigned CW      = cnt_bits(CNT_MAX);
    localparam logic [CW-1:0] PD_LAST   = CW'(PD_CYC - 1);
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);

    seq_state_e    state_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            state_q <= ST_PWRDN;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_PWRDN: begin
                    if (cnt_q == PD_LAST) begin
                        state_q <= ST_WAIT_LOCK;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_WAIT_LOCK: begin
                    cnt_q <= '0;
                    if (lock_ok) state_q <= ST_HOLD;
                end
                ST_HOLD: begin
                    if (!lock_ok) begin
                        state_q <= ST_WAIT_LOCK;
                        cnt_q   <= '0;
                    end else if (cnt_q == HOLD_LAST) begin
                        state_q <= ST_RUN;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    if (!lock_ok && !manual) state_q <= ST_WAIT_LOCK;
                end
            endcase
        end
    end

    always_comb begin
        out.pll_pd = clr || (state_q == ST_PWRDN);
        out.tx_rst = clr || (state_q != ST_RUN);
        out.ready  = !clr && (state_q == ST_RUN);
    end

    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (clr)
        cnt_q <= CW'(CNT_MAX));
    a_r3_release_needs_lock: assert property (@(posedge clk) disable iff (clr)
        $fell(out.tx_rst) |-> ($past(lock_ok) && !$past(out.pll_pd)));
    a_r5_auto_reasserts: assert property (@(posedge clk) disable iff (clr)
        (!manual && out.ready && !lock_ok) |=> out.tx_rst);
    a_r6_manual_keeps: assert property (@(posedge clk) disable iff (clr)
        (manual && out.ready) |=> out.ready);
endmodule

// File: rtl/txrst_ctrl.sv
module txrst_ctrl
    import txrst_pkg::*;
#(
    parameter int unsigned NCH         = 2,
    parameter int unsigned CLK_NS      = 10,
    parameter int unsigned PD_NS       = 1000,
    parameter int unsigned HOLD_NS     = 20,
    parameter int unsigned HYST_NS     = 100,
    parameter int          RECOVERY    = RECOVER_PORT,
    parameter bit          SYNC_REQ    = 1'b1,
    parameter bit          PER_CHANNEL = 1'b1
) (
    input  logic           clk,
    input  logic           rst_req,
    input  logic [NCH-1:0] pll_locked,
    input  logic [NCH-1:0] manual_sel,
    output logic [NCH-1:0] pll_pd,
    output logic [NCH-1:0] tx_dig_rst,
    output logic [NCH-1:0] tx_ready
);
    localparam int unsigned PD_CYC   = ns_to_cycles(PD_NS, CLK_NS);
    localparam int unsigned HOLD_CYC = ns_to_cycles(HOLD_NS, CLK_NS);
    localparam int unsigned HYST_CYC = ns_to_cycles(HYST_NS, CLK_NS);
    localparam int unsigned NSEQ     = PER_CHANNEL ? NCH : 1;

    logic     req_eff;
    seq_out_t seq_out [NSEQ];

    txrst_req_cond #(.SYNC_REQ(SYNC_REQ)) req_i (
        .clk     (clk),
        .req_raw (rst_req),
        .req_eff (req_eff)
    );

    for (genvar g = 0; g < NSEQ; g++) begin : g_seq
        logic lock_in, lock_ok, manual_eff;

        assign lock_in = PER_CHANNEL ? pll_locked[g] : &pll_locked;

        if (RECOVERY == RECOVER_MANUAL) begin : g_man
            assign manual_eff = 1'b1;
        end else if (RECOVERY == RECOVER_PORT) begin : g_port
            assign manual_eff = PER_CHANNEL ? manual_sel[g] : |manual_sel;
        end else begin : g_auto
            assign manual_eff = 1'b0;
        end

        txrst_lock_filter #(.HYST_CYC(HYST_CYC)) filt_i (
            .clk      (clk),
            .clr      (req_eff),
            .lock_raw (lock_in),
            .lock_ok  (lock_ok)
        );

        txrst_seq #(.PD_CYC(PD_CYC), .HOLD_CYC(HOLD_CYC)) seq_i (
            .clk     (clk),
            .clr     (req_eff),
            .lock_ok (lock_ok),
            .manual  (manual_eff),
            .out     (seq_out[g])
        );
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        localparam int unsigned SI = PER_CHANNEL ? c : 0;
        assign pll_pd[c]     = seq_out[SI].pll_pd;
        assign tx_dig_rst[c] = seq_out[SI].tx_rst;
        assign tx_ready[c]   = seq_out[SI].ready;
    end

    a_r1_request_forces_reset: assert property (@(posedge clk)
        rst_req |-> (&pll_pd && &tx_dig_rst && !(|tx_ready)));
    a_r10_ready_matches_release: assert property (@(posedge clk)
        tx_ready == ~tx_dig_rst);
endmodule

// File: tb/txrst_ctrl_tb_top.sv
module txrst_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_a = 1'b1, rst_b = 1'b1;
    logic [1:0] lock_a = 2'b00, lock_b = 2'b00;
    logic [1:0] msel_a = 2'b00, msel_b = 2'b00;
    logic [1:0] pd_a, trst_a, rdy_a, pd_b, trst_b, rdy_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string tag;
        int    val;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    txrst_ctrl #(
        .NCH(2), .CLK_NS(CLK_PERIOD), .PD_NS(45), .HOLD_NS(25), .HYST_NS(35),
        .RECOVERY(2), .SYNC_REQ(1'b1), .PER_CHANNEL(1'b1)
    ) dut_i (
        .clk(clk), .rst_req(rst_a), .pll_locked(lock_a), .manual_sel(msel_a),
        .pll_pd(pd_a), .tx_dig_rst(trst_a), .tx_ready(rdy_a)
    );

    txrst_ctrl #(
        .NCH(2), .CLK_NS(CLK_PERIOD), .PD_NS(45), .HOLD_NS(25), .HYST_NS(35),
        .RECOVERY(0), .SYNC_REQ(1'b0), .PER_CHANNEL(1'b0)
    ) dut_shared_i (
        .clk(clk), .rst_req(rst_b), .pll_locked(lock_b), .manual_sel(msel_b),
        .pll_pd(pd_b), .tx_dig_rst(trst_b), .tx_ready(rdy_b)
    );

    task automatic expect_val(input string tag, input int val);
        exp_t e;
        e.tag = tag;
        e.val = val;
        exp_q.push_back(e);
    endtask

    task automatic observe(input int act);
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (act != e.val) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", e.tag, act, e.val);
        end
    endtask

    function automatic logic probe(input int which);
        case (which)
            0:       return pd_a[0];
            1:       return trst_a[0];
            2:       return trst_a[1];
            3:       return pd_b[0];
            4:       return trst_b[0];
            default: return trst_b[1];
        endcase
    endfunction

    task automatic edges_until(input int which, input logic target, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (probe(which) != target && n < 100);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stimulus
        int n;
        repeat (3) @(negedge clk);

        // R1 reset state, both instances
        expect_val("R1 pd_a", 3);     observe(int'(pd_a));
        expect_val("R1 trst_a", 3);   observe(int'(trst_a));
        expect_val("R1 rdy_a", 0);    observe(int'(rdy_a));
        expect_val("R1 trst_b", 3);   observe(int'(trst_b));

        // R2, R9: synchronized release, 2 stages + 5 power-down cycles
        rst_a = 1'b0;
        edges_until(0, 1'b0, n);
        expect_val("R2 R9 pd_a release edges", 7); observe(n);
        expect_val("R2 pd_a both channels", 0);    observe(int'(pd_a));

        // R3: no lock, digital reset held
        repeat (10) @(negedge clk);
        expect_val("R3 trst_a held without lock", 3); observe(int'(trst_a));

        // R4: 3-cycle lock pulse is filtered, then restart from full rise
        lock_a = 2'b11;
        repeat (3) @(negedge clk);
        lock_a = 2'b00;
        @(negedge clk);
        expect_val("R4 short lock ignored", 3); observe(int'(trst_a));
        lock_a = 2'b11;
        edges_until(1, 1'b0, n);
        expect_val("R3 R4 release edges after lock", 8); observe(n);
        expect_val("R3 ch1 released too", 0);            observe(int'(trst_a));
        expect_val("R10 ready after release", 3);        observe(int'(rdy_a));

        // R5, R7, R8: automatic per channel via port
        msel_a = 2'b00;
        @(negedge clk);
        lock_a[0] = 1'b0;
        edges_until(1, 1'b1, n);
        expect_val("R5 R7 auto reassert edges", 2); observe(n);
        expect_val("R8 ch1 undisturbed", 0);        observe(int'(trst_a[1]));
        expect_val("R10 ready follows reset", 2);   observe(int'(rdy_a));
        lock_a[0] = 1'b1;
        edges_until(1, 1'b0, n);
        expect_val("R5 recovery edges", 8); observe(n);

        // R6, R7: manual on channel 1
        msel_a = 2'b10;
        @(negedge clk);
        lock_a[1] = 1'b0;
        repeat (20) @(negedge clk);
        expect_val("R6 R7 manual keeps release", 0); observe(int'(trst_a[1]));
        expect_val("R6 manual keeps ready", 1);      observe(int'(rdy_a[1]));

        // R1: request asserts outputs before any clock edge
        rst_a = 1'b1;
        #1;
        expect_val("R1 async assert pd_a", 3);   observe(int'(pd_a));
        expect_val("R1 async assert trst_a", 3); observe(int'(trst_a));

        // Shared instance: raw request, automatic, AND of locks
        @(negedge clk);
        rst_b = 1'b0;
        edges_until(3, 1'b0, n);
        expect_val("R2 R9 raw release edges", 5); observe(n);
        lock_b = 2'b01;
        repeat (15) @(negedge clk);
        expect_val("R8 shared needs all locks", 3); observe(int'(trst_b));
        lock_b = 2'b11;
        edges_until(4, 1'b0, n);
        expect_val("R8 shared release edges", 8); observe(n);
        expect_val("R8 shared drives all", 0);    observe(int'(trst_b));
        lock_b[1] = 1'b0;
        edges_until(4, 1'b1, n);
        expect_val("R5 R8 shared auto edges", 2);   observe(n);
        expect_val("R8 shared both reassert", 3);   observe(int'(trst_b));

        rst_b = 1'b1;
        #1;
        expect_val("R9 raw request async assert", 3); observe(int'(pd_b));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule